// File: doc/BRIEF.md
# Memory-Mapped Task File Decoder

This block is the card-side address decoder and data port of a flash storage card that a host reaches in memory-mapped common-memory mode. Each clock in which the host drives exactly one of its active-low read or write strobes, with the register-space pin high and at least one card-enable low, counts as one access. The decoder turns the address and the two card-enables into a task-file register number and a byte lane. It reads or writes the register, or it moves data through one port into a 256-word sector buffer.

The data port has several aliases: offset 0, its duplicates at 8 and 9, and a 1 KB window with the top address bit set. They share one word pointer and one even/odd byte phase, kept by a three-state sequencer. The states are S_IDLE (no transfer, DRQ low), S_EVEN (the next byte access moves the low byte of the current word) and S_ODD (the next byte access moves the high byte). The transitions are CMD (command write, from any state to S_EVEN at word 0), SRST (soft reset through device control, from any state to S_IDLE), EVEN_BYTE (S_EVEN to S_ODD), ADVANCE (S_EVEN or S_ODD to S_EVEN at the next word) and WRAP (the last word moves, to S_IDLE at word 0). Commands are not executed. A command write only arms the buffer transfer.

Top module: `tf_decoder`

## Requirements
- R1: After reset, the status register at offset 7 and the alternate status at offset 14 read 0x50. Bit 7 is BSY=0, bit 6 DRDY=1, bit 5 DWF=0, bit 4 DSC=1, bit 3 DRQ, bit 2 CORR=0, bit 1 IDX=0, bit 0 ERR=0. Offsets 2 to 6 read 0.
- R2: An access happens only when reg_n is high, at least one of ce1_n/ce2_n is low, and exactly one of oe_n/we_n is low. At all other times rdata is 0 and no state changes.
- R3: With addr[10] low, addr[3:0] selects the register. Offsets 2 to 6 are read/write bytes, with card/head at offset 6. Offsets 1 and 13 read the error byte (always 0) and take feature writes. Offset 15 reads the drive address {1,1,~head[3:0],~card,card}, where head is card/head bits 3..0 and card is bit 4. Writes to offset 15 are ignored.
- R4: With addr[10] high, an even address reaches the data port as offset 8 and an odd address as offset 9.
- R5: A word access (both card-enables low) to offset 0, 8 or 9 moves the whole current word and advances the pointer by one word. A word access to any other offset n reaches register n with bit 0 cleared on bits 7..0 and register n with bit 0 set on bits 15..8.
- R6: A byte access with only ce1_n low to offset 0 or 8 uses bits 7..0. It moves the low byte of the current word in S_EVEN and the high byte in S_ODD, and the pointer advances after the high byte.
- R7: A byte access with only ce1_n low to offset 9 moves the high byte of the current word on bits 7..0, advances the pointer and returns to S_EVEN.
- R8: A byte access with only ce2_n low forces address bit 0 to 1 and uses bits 15..8. At offset 0 it reaches error/features and leaves the data pointer unchanged. At offset 8 it moves the high byte of the current word.
- R9: A write to offset 7 (the command) sets DRQ, so status reads 0x58, and puts the pointer at the low byte of word 0, even in the middle of a transfer.
- R10: When the last of the 256 words moves, DRQ clears (status 0x50) and the pointer wraps to word 0.
- R11: While DRQ is low, data-port reads return 0, data-port writes leave the buffer unchanged and the pointer holds.
- R12: A write to offset 14 with bit 2 set clears DRQ and returns the pointer to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Host address; bit 10 selects the data window |
| reg_n | input | 1 | Active-low register-space select; must be high for common memory |
| ce1_n | input | 1 | Active-low enable of bits 7..0 |
| ce2_n | input | 1 | Active-low enable of bits 15..8 |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| wdata | input | 16 | Write data; bits 7..0 even byte, 15..8 odd byte |
| rdata | output | 16 | Read data, 0 when no read is in progress |

## Verification
A wrong byte phase or word index shows on the very next data read as a byte from the neighbouring position or word. The bench therefore reads back a whole sector through randomly mixed aliases and compares every access against a bench-side copy. A sequencer stuck in the wrong state shows at the next status read as a wrong DRQ bit, and a stray advance during an error/feature access or an idle access shows as a one-word shift on the next data read. A broken command or soft-reset path shows on the first data access after it as data from some word other than word 0.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
    typedef enum logic [1:0] {S_IDLE, S_EVEN, S_ODD} seq_state_t;
    typedef enum logic [1:0] {LANE_NONE, LANE_WORD, LANE_LO, LANE_HI} lane_t;
    typedef enum logic [1:0] {DK_NONE, DK_WORD, DK_SEQ, DK_ODD} dkind_t;

    localparam logic [3:0] OFF_DATA     = 4'd0;
    localparam logic [3:0] OFF_STATCMD  = 4'd7;
    localparam logic [3:0] OFF_DUP_EVEN = 4'd8;
    localparam logic [3:0] OFF_DUP_ODD  = 4'd9;
    localparam logic [3:0] OFF_ALT_CTL  = 4'd14;
    localparam logic [3:0] OFF_DRVADDR  = 4'd15;
    localparam logic [3:0] OFF_CARDHEAD = 4'd6;
    localparam int         SRST_BIT     = 2;
endpackage

// File: rtl/tfd_decode.sv
module tfd_decode
    import tfd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              rd,
    output logic              wr,
    output lane_t             lane,
    output dkind_t            dk,
    output logic [3:0]        reg_lo,
    output logic [3:0]        reg_hi
);
    logic       sel;
    logic [3:0] off;
    logic       unused_addr;

    assign unused_addr = ^addr[ADDR_W-2:4];

    always_comb begin
        sel = reg_n && !(ce1_n && ce2_n);
        rd  = sel && !oe_n && we_n;
        wr  = sel && oe_n && !we_n;
        // window: even address -> duplicate even data, odd -> duplicate odd data
        off = addr[ADDR_W-1] ? {3'b100, addr[0]} : addr[3:0];

        if (!(rd || wr))           lane = LANE_NONE;
        else if (!ce1_n && !ce2_n) lane = LANE_WORD;
        else if (!ce1_n)           lane = LANE_LO;
        else                       lane = LANE_HI;

        reg_lo = (lane == LANE_WORD) ? {off[3:1], 1'b0} : off;
        reg_hi = {off[3:1], 1'b1};

        dk = DK_NONE;
        unique case (lane)
            LANE_WORD: if (reg_lo == OFF_DATA || reg_lo == OFF_DUP_EVEN) dk = DK_WORD;
            LANE_LO: begin
                if (reg_lo == OFF_DATA || reg_lo == OFF_DUP_EVEN) dk = DK_SEQ;
                else if (reg_lo == OFF_DUP_ODD)                   dk = DK_ODD;
            end
            LANE_HI:   if (reg_hi == OFF_DUP_ODD) dk = DK_ODD;
            default:   dk = DK_NONE;
        endcase
    end
endmodule

// File: rtl/tfd_seq.sv
module tfd_seq
    import tfd_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dkind_t           dk,
    input  logic             cmd_wr,
    input  logic             srst_wr,
    output logic [IDX_W-1:0] idx,
    output logic             drq,
    output logic             phase_odd
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             adv;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        adv     = 1'b0;
        if (cmd_wr) begin                       // CMD
            state_d = S_EVEN;
            idx_d   = '0;
        end else if (srst_wr) begin             // SRST
            state_d = S_IDLE;
            idx_d   = '0;
        end else if (dk != DK_NONE) begin
            unique case (state_q)
                S_IDLE:  adv = 1'b0;
                S_EVEN:  if (dk == DK_SEQ) state_d = S_ODD;  // EVEN_BYTE
                         else adv = 1'b1;
                S_ODD:   adv = 1'b1;
                default: state_d = S_IDLE;
            endcase
            if (adv) begin
                if (idx_q == LAST) begin        // WRAP
                    state_d = S_IDLE;
                    idx_d   = '0;
                end else begin                  // ADVANCE
                    state_d = S_EVEN;
                    idx_d   = idx_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        idx       = idx_q;
        drq       = (state_q != S_IDLE);
        phase_odd = (state_q == S_ODD);
    end
endmodule

// File: rtl/tfd_sector_buf.sv
module tfd_sector_buf #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [15:0]      wword,
    output logic [15:0]      rword
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_lo) mem[idx][7:0]  <= wword[7:0];
        if (we_hi) mem[idx][15:8] <= wword[15:8];
    end

    assign rword = mem[idx];
endmodule

// File: rtl/tfd_taskfile.sv
module tfd_taskfile
    import tfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  lane_t       lane,
    input  logic [3:0]  reg_lo,
    input  logic [3:0]  reg_hi,
    input  logic [15:0] wdata,
    input  logic        drq,
    output logic [7:0]  tf_lo,
    output logic [7:0]  tf_hi,
    output logic        cmd_wr,
    output logic        srst_wr
);
    localparam int FIRST_RW = 2;
    localparam int LAST_RW  = 6;
    localparam int N_RW     = LAST_RW - FIRST_RW + 1;

    logic                 wr_lo, wr_hi;
    logic [N_RW-1:0][7:0] rwv;
    logic [7:0]           status, drvaddr, card_head;

    assign wr_lo = wr && (lane == LANE_WORD || lane == LANE_LO);
    assign wr_hi = wr && (lane == LANE_WORD || lane == LANE_HI);

    for (genvar k = FIRST_RW; k <= LAST_RW; k++) begin : g_rw
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (wr_lo && reg_lo == 4'(k))       q <= wdata[7:0];
            else if (wr_hi && reg_hi == 4'(k))       q <= wdata[15:8];
        end
        assign rwv[k-FIRST_RW] = q;
    end

    assign card_head = rwv[OFF_CARDHEAD - 4'(FIRST_RW)];
    assign status    = {1'b0, 1'b1, 1'b0, 1'b1, drq, 3'b000};
    assign drvaddr   = {2'b11, ~card_head[3:0], ~card_head[4], card_head[4]};

    function automatic logic [7:0] pick(input logic [3:0] n, input logic [N_RW-1:0][7:0] v,
                                        input logic [7:0] st, input logic [7:0] da);
        logic [7:0] r;
        r = 8'h00;
        if (n >= 4'(FIRST_RW) && n <= 4'(LAST_RW)) r = v[n - 4'(FIRST_RW)];
        else if (n == OFF_STATCMD || n == OFF_ALT_CTL) r = st;
        else if (n == OFF_DRVADDR)                     r = da;
        return r;
    endfunction

    always_comb begin
        tf_lo   = pick(reg_lo, rwv, status, drvaddr);
        tf_hi   = pick(reg_hi, rwv, status, drvaddr);
        cmd_wr  = (wr_lo && reg_lo == OFF_STATCMD) || (wr_hi && reg_hi == OFF_STATCMD);
        srst_wr = wr_lo && reg_lo == OFF_ALT_CTL && wdata[SRST_BIT];
    end
endmodule

// File: rtl/tf_decoder.sv
module tf_decoder
    import tfd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int WORDS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              reg_n,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int IDX_W = $clog2(WORDS);

    logic             rd, wr, cmd_wr, srst_wr, drq, phase_odd;
    logic             we_lo, we_hi, live_wr;
    lane_t            lane;
    dkind_t           dk;
    logic [3:0]       reg_lo, reg_hi;
    logic [7:0]       tf_lo, tf_hi, in_byte, dbyte;
    logic [IDX_W-1:0] idx;
    logic [15:0]      rword, wword;

    tfd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
        .rd(rd), .wr(wr), .lane(lane), .dk(dk), .reg_lo(reg_lo), .reg_hi(reg_hi)
    );

    tfd_taskfile u_tf (
        .clk(clk), .rst_n(rst_n), .wr(wr), .lane(lane), .reg_lo(reg_lo), .reg_hi(reg_hi),
        .wdata(wdata), .drq(drq), .tf_lo(tf_lo), .tf_hi(tf_hi), .cmd_wr(cmd_wr), .srst_wr(srst_wr)
    );

    tfd_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .dk(dk), .cmd_wr(cmd_wr), .srst_wr(srst_wr),
        .idx(idx), .drq(drq), .phase_odd(phase_odd)
    );

    always_comb begin
        in_byte = (lane == LANE_HI) ? wdata[15:8] : wdata[7:0];
        live_wr = drq && wr;
        we_lo   = live_wr && (dk == DK_WORD || (dk == DK_SEQ && !phase_odd));
        we_hi   = live_wr && (dk == DK_WORD || dk == DK_ODD || (dk == DK_SEQ && phase_odd));
        wword   = (dk == DK_WORD) ? wdata : {in_byte, in_byte};
    end

    tfd_sector_buf #(.WORDS(WORDS), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .idx(idx), .we_lo(we_lo), .we_hi(we_hi), .wword(wword), .rword(rword)
    );

    always_comb begin
        dbyte = '0;
        if (drq) dbyte = (dk == DK_SEQ && !phase_odd) ? rword[7:0] : rword[15:8];
        rdata = '0;
        if (rd) begin
            unique case (dk)
                DK_WORD:        rdata = drq ? rword : '0;
                DK_SEQ, DK_ODD: rdata = (lane == LANE_HI) ? {dbyte, 8'h00} : {8'h00, dbyte};
                default: begin
                    unique case (lane)
                        LANE_WORD: rdata = {tf_hi, tf_lo};
                        LANE_LO:   rdata = {8'h00, tf_lo};
                        LANE_HI:   rdata = {tf_hi, 8'h00};
                        default:   rdata = '0;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/tfd_checker.sv
module tfd_checker
    import tfd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int WORDS  = 256,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              reg_n,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic              drq,
    input logic [IDX_W-1:0]  idx,
    input dkind_t            dk
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    logic lo_wr, lo_rd, host_rd;
    assign lo_wr   = reg_n && !ce1_n && ce2_n && oe_n && !we_n && !addr[ADDR_W-1];
    assign lo_rd   = reg_n && !ce1_n && ce2_n && !oe_n && we_n && !addr[ADDR_W-1];
    assign host_rd = reg_n && (!ce1_n || !ce2_n) && !oe_n && we_n;

    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> rdata == 16'h0000);

    a_r1_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && addr[3:0] == OFF_STATCMD) |->
        (rdata[15:8] == 8'h00 && rdata[7:4] == 4'b0101 && rdata[2:0] == 3'b000 && rdata[3] == drq));

    a_r9_cmd_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && addr[3:0] == OFF_STATCMD) |=> (drq && idx == '0));

    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && addr[3:0] == OFF_ALT_CTL && wdata[SRST_BIT]) |=> !drq);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!drq && dk != DK_NONE) |=> (!drq && $stable(idx)));

    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && idx == LAST && dk == DK_WORD) |=> (!drq && idx == '0));
endmodule

bind tf_decoder tfd_checker #(.ADDR_W(ADDR_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .oe_n(oe_n), .we_n(we_n), .wdata(wdata), .rdata(rdata), .drq(drq), .idx(idx), .dk(dk)
);

// File: tb/tb_tf_decoder.sv
module tb_tf_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] addr;
    logic        reg_n, ce1_n, ce2_n, oe_n, we_n;
    logic [15:0] wdata;
    logic [15:0] rdata;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] exp_buf [256];

    always #10 clk = ~clk;

    tf_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .reg_n(reg_n), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .oe_n(oe_n), .we_n(we_n), .wdata(wdata), .rdata(rdata)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog R1: act=timeout exp=completion");
        summary();
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input bit r_n, input bit is_rd, input bit c1, input bit c2,
                       input logic [10:0] a, input logic [15:0] wd, output logic [15:0] rv);
        @(negedge clk);
        reg_n = r_n; ce1_n = c1; ce2_n = c2; addr = a; wdata = wd;
        oe_n = !is_rd; we_n = is_rd;
        #5 rv = rdata;
        @(negedge clk);
        oe_n = 1'b1; we_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
    endtask

    task automatic tf_w(input logic [3:0] off, input logic [7:0] v);
        logic [15:0] rv;
        bus(1, 0, 0, 1, {7'h00, off}, {8'h00, v}, rv);
    endtask

    task automatic tf_chk(input string tag, input logic [3:0] off, input logic [7:0] exp);
        logic [15:0] rv;
        bus(1, 1, 0, 1, {7'h00, off}, 16'h0000, rv);
        chk(tag, rv, {8'h00, exp});
    endtask

    function automatic logic [10:0] win_addr(input bit odd);
        logic [10:0] a;
        a = 11'h400 | 11'($urandom_range(0, 1023));
        return odd ? (a | 11'h001) : (a & 11'h7FE);
    endfunction

    function automatic logic [7:0] drv_addr(input logic [7:0] ch);
        return {2'b11, ~ch[3:0], ~ch[4], ch[4]};
    endfunction

    // one word through the data port by alias mode m; on reads every access is checked
    task automatic xfer(input bit is_rd, input int m, input logic [15:0] w);
        logic [15:0] rv;
        unique case (m)
            0: begin
                bus(1, is_rd, 0, 0, 11'h000, w, rv);
                if (is_rd) chk("R5 word@0", rv, w);
            end
            1: begin
                bus(1, is_rd, 0, 0, win_addr($urandom_range(0, 1) == 1), w, rv);
                if (is_rd) chk("R4/R5 word window", rv, w);
            end
            2: begin
                bus(1, is_rd, 0, 1, 11'h000, {8'h00, w[7:0]}, rv);
                if (is_rd) chk("R6 even byte@0", rv, {8'h00, w[7:0]});
                bus(1, is_rd, 0, 1, 11'h000, {8'h00, w[15:8]}, rv);
                if (is_rd) chk("R6 odd byte@0", rv, {8'h00, w[15:8]});
            end
            3: begin
                bus(1, is_rd, 0, 1, 11'h008, {8'h00, w[7:0]}, rv);
                if (is_rd) chk("R6 byte@8", rv, {8'h00, w[7:0]});
                bus(1, is_rd, 0, 1, 11'h009, {8'h00, w[15:8]}, rv);
                if (is_rd) chk("R7 byte@9", rv, {8'h00, w[15:8]});
            end
            4: begin
                bus(1, is_rd, 0, 1, win_addr(0), {8'h00, w[7:0]}, rv);
                if (is_rd) chk("R4 window even", rv, {8'h00, w[7:0]});
                bus(1, is_rd, 0, 1, win_addr(1), {8'h00, w[15:8]}, rv);
                if (is_rd) chk("R4 window odd", rv, {8'h00, w[15:8]});
            end
            default: begin
                bus(1, is_rd, 0, 1, 11'h008, {8'h00, w[7:0]}, rv);
                if (is_rd) chk("R6 byte@8", rv, {8'h00, w[7:0]});
                bus(1, is_rd, 1, 0, 11'h008, {w[15:8], 8'h00}, rv);
                if (is_rd) chk("R8 ce2 byte@8", rv, {w[15:8], 8'h00});
            end
        endcase
    endtask

    initial begin
        logic [15:0] rv;
        logic [7:0]  tv [2:6];
        void'($urandom(32'd7731));
        rst_n = 1'b0; reg_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1;
        oe_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        tf_chk("R1 status", 4'd7, 8'h50);
        tf_chk("R1 alt status", 4'd14, 8'h50);
        for (int k = 2; k <= 6; k++) tf_chk("R1 taskfile zero", 4'(k), 8'h00);

        // task file random read/write
        for (int rep = 0; rep < 4; rep++) begin
            for (int k = 2; k <= 6; k++) begin
                tv[k] = 8'($urandom);
                tf_w(4'(k), tv[k]);
            end
            for (int k = 2; k <= 6; k++) tf_chk("R3 taskfile rw", 4'(k), tv[k]);
        end
        tf_w(4'd1, 8'hA5);
        tf_chk("R3 error reads 0", 4'd1, 8'h00);
        tf_chk("R3 dup error reads 0", 4'd13, 8'h00);
        tf_w(4'd6, 8'h1A);
        tf_chk("R3 drive address", 4'd15, drv_addr(8'h1A));
        tf_w(4'd15, 8'h77);
        tf_chk("R3 drive address after write", 4'd15, drv_addr(8'h1A));
        tf_chk("R3 card/head after offset 15 write", 4'd6, 8'h1A);

        // word access to task file
        bus(1, 0, 0, 0, 11'h002, 16'hBBAA, rv);
        tf_chk("R5 word lo lane", 4'd2, 8'hAA);
        tf_chk("R5 word hi lane", 4'd3, 8'hBB);
        bus(1, 1, 0, 0, 11'h002, 16'h0000, rv);
        chk("R5 word read taskfile", rv, 16'hBBAA);

        // qualification of accesses
        bus(0, 1, 0, 1, 11'h007, 16'h0000, rv);
        chk("R2 reg_n low read", rv, 16'h0000);
        bus(0, 0, 0, 1, 11'h002, 16'h0033, rv);
        tf_chk("R2 reg_n low write ignored", 4'd2, 8'hAA);
        bus(1, 1, 1, 1, 11'h007, 16'h0000, rv);
        chk("R2 no card enable", rv, 16'h0000);

        // idle data port
        bus(1, 1, 0, 0, 11'h000, 16'h0000, rv);
        chk("R11 idle data read", rv, 16'h0000);

        // fill a sector
        tf_w(4'd7, 8'h30);
        tf_chk("R9 status after command", 4'd7, 8'h58);
        for (int i = 0; i < 256; i++) begin
            exp_buf[i] = 16'($urandom);
            if (i == 255) tf_chk("R10 DRQ before last word", 4'd7, 8'h58);
            xfer(0, $urandom_range(0, 5), exp_buf[i]);
        end
        tf_chk("R10 DRQ clear after last word", 4'd7, 8'h50);

        // read it back through mixed aliases
        tf_w(4'd7, 8'h20);
        for (int i = 0; i < 256; i++) xfer(1, $urandom_range(0, 5), exp_buf[i]);
        tf_chk("R10 status after read sector", 4'd14, 8'h50);

        // idle write ignored, command returns to word 0
        bus(1, 0, 0, 0, 11'h000, 16'hDEAD, rv);
        tf_w(4'd7, 8'h20);
        xfer(1, 0, exp_buf[0]);
        // command in mid transfer
        bus(1, 1, 0, 1, 11'h008, 16'h0000, rv);
        chk("R6 even byte of word 1", rv, {8'h00, exp_buf[1][7:0]});
        tf_w(4'd7, 8'h20);
        bus(1, 1, 0, 1, 11'h008, 16'h0000, rv);
        chk("R9 pointer back to even byte of word 0", rv, {8'h00, exp_buf[0][7:0]});
        bus(1, 1, 0, 1, 11'h000, 16'h0000, rv);
        chk("R6 odd byte of word 0", rv, {8'h00, exp_buf[0][15:8]});

        // offset 9 alone
        bus(1, 1, 0, 1, 11'h009, 16'h0000, rv);
        chk("R7 byte@9 odd of word 1", rv, {8'h00, exp_buf[1][15:8]});
        bus(1, 1, 0, 1, 11'h008, 16'h0000, rv);
        chk("R7 next access even of word 2", rv, {8'h00, exp_buf[2][7:0]});
        bus(1, 1, 0, 1, 11'h009, 16'h0000, rv);
        chk("R7 byte@9 odd of word 2", rv, {8'h00, exp_buf[2][15:8]});

        // ce2-only accesses
        bus(1, 1, 1, 0, 11'h000, 16'h0000, rv);
        chk("R8 ce2 offset 0 is error", rv, 16'h0000);
        bus(1, 0, 1, 0, 11'h000, 16'hFF00, rv);
        xfer(1, 0, exp_buf[3]);
        bus(1, 1, 1, 0, 11'h008, 16'h0000, rv);
        chk("R8 ce2 offset 8 odd byte", rv, {exp_buf[4][15:8], 8'h00});
        xfer(1, 0, exp_buf[5]);

        // soft reset
        tf_w(4'd14, 8'h04);
        tf_chk("R12 DRQ clear after soft reset", 4'd7, 8'h50);
        bus(1, 1, 0, 0, 11'h000, 16'h0000, rv);
        chk("R12 data read after soft reset", rv, 16'h0000);
        tf_w(4'd14, 8'h00);
        tf_w(4'd7, 8'h20);
        xfer(1, 0, exp_buf[0]);
        xfer(1, 3, exp_buf[1]);

        summary();
    end
endmodule